// File: doc/BRIEF.md
# Single-Bit Alias Bridge

This bridge sits between a requester and a backing memory or peripheral region. It gives every bit of that region its own word-aligned address inside a 32 MB alias window. A requester can then test or change one bit with a single load or store, without doing a read-modify-write of its own.

On an alias read, the bridge fetches the byte, halfword or word that holds the addressed bit from the target. It returns 0 or 1 in bit 0 of the response. On an alias write, it reads the same unit, sets or clears only the addressed bit according to bit 0 of the write data, and writes the unit back. The master-side request stays asserted from the fetch through the write-back, so the modification is indivisible.

The region base is a parameter. A typical system uses two copies of the block: one aliasing a memory region and one aliasing a peripheral region.

Top module: `bitalias_bridge`

## Requirements
- R1: While reset is high, and in the first cycle after it, `s_ready` and `m_req` are 0.
- R2: The target address is `TARGET_BASE | ((s_addr & 0x1FFFFFF) >> 5)`. For halfword accesses, bit 0 of that address is cleared. For word accesses, bits 1:0 are cleared. Alias address bits above bit 24 have no effect.
- R3: The access size codes are 0 for byte, 1 for halfword and 2 for word; code 3 acts as word. The bit index is `s_addr[6:2]`, masked to 3 bits for byte, 4 bits for halfword and 5 bits for word. The index counts from the least significant bit of the unit. Target units travel little-endian and right-aligned on `m_rdata` and `m_wdata`, with byte n at bits 8n+7:8n.
- R4: `m_size` equals the alias access size on every target handshake. `m_addr` and `m_size` hold steady while `m_req` waits for `m_ready`.
- R5: An alias read performs exactly one target read and no target write. Its response has bit 0 equal to the selected bit of the fetched unit and all other bits zero. A write response is all zero.
- R6: An alias write performs one target read and then one target write to the same address. The written unit equals the fetched unit with only the selected bit replaced by `s_wdata[0]`.
- R7: Bits 31:1 of `s_wdata` have no effect on what is written.
- R8: `m_req` stays high without a gap from the start of the target read until the write-back handshake. A new alias request is only taken after `s_ready` has been given for the current one.
- R9: `s_ready` is a one-cycle pulse in the cycle right after the last target handshake of the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req | input | 1 | Alias request, held until `s_ready` |
| s_addr | input | 32 | Alias address |
| s_size | input | 2 | Access size code |
| s_write | input | 1 | 1 for write, 0 for read |
| s_wdata | input | 32 | Write data; only bit 0 is used |
| s_ready | output | 1 | Completion pulse |
| s_rdata | output | 32 | Response, valid with `s_ready` |
| m_req | output | 1 | Target request |
| m_write | output | 1 | Target write enable |
| m_addr | output | 32 | Target byte address |
| m_size | output | 2 | Target access size code |
| m_wdata | output | 32 | Target write unit, right-aligned |
| m_ready | input | 1 | Target handshake completion |
| m_rdata | input | 32 | Target read unit, right-aligned |

## Verification
The bench aims at odd byte addresses under halfword access and at misaligned word addresses. A bridge that forgot to clear the low address bits would show up as a wrong `m_addr` and a wrong bit. It also covers bit 31 of a word and the top address of the window. There, an unmasked or unshifted offset leaves the region, and a width-blind index selects a bit outside the unit.

Writes use data whose bit 0 disagrees with the upper bits. A bridge that tested the whole word rather than bit 0 would set where it should clear. The bench then compares the whole target memory, so any neighbouring bit that gets disturbed is caught.

Target latency varies from zero to several cycles. A bridge that dropped `m_req` between fetch and write-back would break atomicity. One that pulsed `s_ready` early would return the result before the target answered.

// File: rtl/bitalias_pkg.sv
package bitalias_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_DONE
    } seq_state_e;

    localparam int UNIT_W = 32;
    localparam int IDX_W  = 5;

    typedef struct packed {
        logic [31:0]      taddr;
        logic [IDX_W-1:0] idx;
        acc_size_e        size;
        logic             write;
        logic             wbit;
    } alias_op_t;

    function automatic logic [UNIT_W-1:0] unit_mask(acc_size_e s);
        case (s)
            ACC_BYTE: return 32'h0000_00FF;
            ACC_HALF: return 32'h0000_FFFF;
            default:  return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/bitalias_decode.sv
module bitalias_decode
    import bitalias_pkg::*;
#(
    parameter logic [31:0] TARGET_BASE = 32'h2000_0000,
    parameter int          WIN_BITS    = 25,
    parameter int          BIT_SHIFT   = 5
) (
    input  logic [31:0]      alias_addr,
    input  acc_size_e        size,
    output logic [31:0]      taddr,
    output logic [IDX_W-1:0] idx
);
    localparam logic [31:0] WIN_MASK = (32'd1 << WIN_BITS) - 32'd1;

    logic [31:0] raw_addr;
    logic        unused_hi;

    assign unused_hi = ^alias_addr[31:WIN_BITS];
    assign raw_addr  = TARGET_BASE | ((alias_addr & WIN_MASK) >> BIT_SHIFT);

    always_comb begin
        case (size)
            ACC_BYTE: begin
                taddr = raw_addr;
                idx   = {2'b00, alias_addr[4:2]};
            end
            ACC_HALF: begin
                taddr = raw_addr & ~32'd1;
                idx   = {1'b0, alias_addr[5:2]};
            end
            default: begin
                taddr = raw_addr & ~32'd3;
                idx   = alias_addr[6:2];
            end
        endcase
    end
endmodule

// File: rtl/bitalias_merge.sv
module bitalias_merge
    import bitalias_pkg::*;
(
    input  logic [UNIT_W-1:0] unit,
    input  acc_size_e         size,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wbit,
    output logic              rbit,
    output logic [UNIT_W-1:0] merged
);
    logic [UNIT_W-1:0] sel;

    assign sel    = {{(UNIT_W-1){1'b0}}, 1'b1} << idx;
    assign rbit   = |(unit & sel);
    assign merged = (wbit ? (unit | sel) : (unit & ~sel)) & unit_mask(size);
endmodule

// File: rtl/bitalias_seq.sv
module bitalias_seq
    import bitalias_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       s_req,
    input  logic       op_write,
    input  logic       m_ready,
    output logic       accept,
    output logic       capture,
    output logic       m_req,
    output logic       m_write,
    output logic       s_ready
);
    seq_state_e state, state_nx;

    assign accept  = (state == ST_IDLE) && s_req;
    assign capture = (state == ST_FETCH) && m_ready;
    assign m_req   = (state == ST_FETCH) || (state == ST_STORE);
    assign m_write = (state == ST_STORE);
    assign s_ready = (state == ST_DONE);

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (s_req) state_nx = ST_FETCH;
            ST_FETCH: if (m_ready) state_nx = op_write ? ST_STORE : ST_DONE;
            ST_STORE: if (m_ready) state_nx = ST_DONE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // R8: the write-back follows the fetch with no gap in m_req
    assert_hold_req_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && m_ready && op_write) |=> (m_req && m_write));

    // R9: completion is a single-cycle pulse
    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        s_ready |=> !s_ready);

    // R9: completion comes right after a target handshake
    assert_ready_after_hs_R9: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> $past(m_req && m_ready));
endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge
    import bitalias_pkg::*;
#(
    parameter logic [31:0] TARGET_BASE = 32'h2000_0000,
    parameter int          WIN_BITS    = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        s_req,
    input  logic [31:0] s_addr,
    input  logic [1:0]  s_size,
    input  logic        s_write,
    input  logic [31:0] s_wdata,
    output logic        s_ready,
    output logic [31:0] s_rdata,
    output logic        m_req,
    output logic        m_write,
    output logic [31:0] m_addr,
    output logic [1:0]  m_size,
    output logic [31:0] m_wdata,
    input  logic        m_ready,
    input  logic [31:0] m_rdata
);
    alias_op_t         op_q;
    logic [UNIT_W-1:0] unit_q;
    logic [31:0]       dec_taddr;
    logic [IDX_W-1:0]  dec_idx;
    logic              accept, capture, rbit;
    logic [UNIT_W-1:0] merged;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^s_wdata[31:1];

    bitalias_decode #(
        .TARGET_BASE (TARGET_BASE),
        .WIN_BITS    (WIN_BITS),
        .BIT_SHIFT   (5)
    ) i_decode (
        .alias_addr (s_addr),
        .size       (acc_size_e'(s_size)),
        .taddr      (dec_taddr),
        .idx        (dec_idx)
    );

    bitalias_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .s_req    (s_req),
        .op_write (op_q.write),
        .m_ready  (m_ready),
        .accept   (accept),
        .capture  (capture),
        .m_req    (m_req),
        .m_write  (m_write),
        .s_ready  (s_ready)
    );

    bitalias_merge i_merge (
        .unit   (unit_q),
        .size   (op_q.size),
        .idx    (op_q.idx),
        .wbit   (op_q.wbit),
        .rbit   (rbit),
        .merged (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            unit_q <= '0;
        end else begin
            if (accept) begin
                op_q.taddr <= dec_taddr;
                op_q.idx   <= dec_idx;
                op_q.size  <= acc_size_e'(s_size);
                op_q.write <= s_write;
                op_q.wbit  <= s_wdata[0];
            end
            if (capture) unit_q <= m_rdata & unit_mask(op_q.size);
        end
    end

    assign m_addr  = op_q.taddr;
    assign m_size  = op_q.size;
    assign m_wdata = merged;
    assign s_rdata = (s_ready && !op_q.write) ? {31'd0, rbit} : 32'd0;

    // R4: target address and size hold while the target stalls
    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_ready) |=> ($stable(m_addr) && $stable(m_size)));

    // R6: the write-back differs from the fetched unit in at most one bit
    assert_one_bit_R6: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_write) |-> ($countones(m_wdata ^ unit_q) <= 1));

    // R5: read responses carry only bit 0
    assert_rd_result_R5: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (s_rdata[31:1] == 31'd0));

    // R5: a read never reaches the target as a write
    assert_no_write_on_read_R5: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_write) |-> op_q.write);
endmodule

// File: tb/test_bitalias_bridge.sv
`timescale 1ns/1ps
module test_bitalias_bridge;
    localparam logic [31:0] BASE  = 32'h2000_0000;
    localparam logic [31:0] ALIAS = 32'h2200_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_req = 1'b0;
    logic [31:0] s_addr = '0;
    logic [1:0]  s_size = '0;
    logic        s_write = 1'b0;
    logic [31:0] s_wdata = '0;
    logic        s_ready;
    logic [31:0] s_rdata;
    logic        m_req, m_write, m_ready;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [1:0]  m_size;

    always #10 clk = ~clk;

    bitalias_bridge #(.TARGET_BASE(BASE), .WIN_BITS(25)) i_bitalias_bridge (
        .clk(clk), .rst(rst),
        .s_req(s_req), .s_addr(s_addr), .s_size(s_size), .s_write(s_write),
        .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata),
        .m_req(m_req), .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
        .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- target memory model ----------------
    logic [7:0] mem    [64];
    logic [7:0] shadow [64];
    int lat = 0;
    int cnt = 0;
    int cyc = 0;
    int last_hs_cyc = -10;
    int hs_count = 0;
    bit gap_seen = 0;
    logic [31:0] exp_maddr, exp_wdata;
    logic [1:0]  exp_msize;
    bit exp_write = 0;

    assign m_ready = m_req && (cnt >= lat);

    always_comb begin
        m_rdata = '0;
        for (int n = 0; n < 4; n++)
            if (n < (m_size == 2'd0 ? 1 : m_size == 2'd1 ? 2 : 4))
                m_rdata[8*n +: 8] = mem[(m_addr[5:0] + n) & 63];
    end

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (rst) cnt <= 0;
        else if (m_req && m_ready) begin
            cnt <= 0;
            last_hs_cyc <= cyc;
            check(m_addr == exp_maddr, "R2 target address", m_addr, exp_maddr);
            check(m_size == exp_msize, "R4 target size", {30'd0, m_size}, {30'd0, exp_msize});
            if (hs_count == 0) begin
                check(!m_write, "R5/R6 first handshake is a read", {31'd0, m_write}, 32'd0);
            end else begin
                check(m_write && exp_write, "R6 second handshake is a write", {31'd0, m_write}, 32'd1);
                check(m_wdata == exp_wdata, "R6 write-back unit", m_wdata, exp_wdata);
                for (int n = 0; n < 4; n++)
                    if (n < (m_size == 2'd0 ? 1 : m_size == 2'd1 ? 2 : 4))
                        mem[(m_addr[5:0] + n) & 63] <= m_wdata[8*n +: 8];
            end
            hs_count <= hs_count + 1;
        end else if (m_req) cnt <= cnt + 1;
        if (!rst && exp_write && hs_count == 1 && !m_req) gap_seen <= 1;
    end

    // ---------------- scoreboard ----------------
    logic [31:0] exp_q[$];

    always @(negedge clk) begin
        if (!rst && s_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R8 unexpected completion", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(s_rdata == e, "R5 response data", s_rdata, e);
                check(cyc == last_hs_cyc + 1, "R9 ready timing", cyc, last_hs_cyc + 1);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                          input logic [31:0] wd, input int l);
        logic [31:0] ta, unit, nunit;
        int idx, nb, off;
        ta = BASE | ((a & 32'h01FF_FFFF) >> 5);
        if (sz == 2'd0) begin nb = 1; idx = (a >> 2) & 7; end
        else if (sz == 2'd1) begin nb = 2; idx = (a >> 2) & 15; ta = ta & ~32'd1; end
        else begin nb = 4; idx = (a >> 2) & 31; ta = ta & ~32'd3; end
        off = ta[5:0];
        unit = '0;
        for (int n = 0; n < nb; n++) unit[8*n +: 8] = shadow[(off + n) & 63];
        nunit = unit;
        nunit[idx] = wd[0];
        if (wr) for (int n = 0; n < nb; n++) shadow[(off + n) & 63] = nunit[8*n +: 8];
        exp_maddr = ta;
        exp_msize = sz;
        exp_wdata = nunit;
        exp_write = wr;
        hs_count  = 0;
        gap_seen  = 0;
        lat       = l;
        exp_q.push_back(wr ? 32'd0 : {31'd0, unit[idx]});
        @(negedge clk);
        s_req = 1; s_addr = a; s_size = sz; s_write = wr; s_wdata = wd;
        do @(negedge clk); while (!s_ready);
        s_req = 0;
        check(hs_count == (wr ? 2 : 1), wr ? "R6 handshake count" : "R5 handshake count",
              hs_count, wr ? 2 : 1);
        if (wr) check(!gap_seen, "R8 m_req held through write-back", {31'd0, gap_seen}, 32'd0);
        @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired", 32'd0, 32'd1);
        report();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]    = 8'((i * 37 + 5) ^ (i << 3));
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        check(!s_ready && !m_req, "R1 outputs idle in reset", {30'd0, s_ready, m_req}, 32'd0);
        rst = 0;
        @(negedge clk);
        check(!s_ready && !m_req, "R1 outputs idle after reset", {30'd0, s_ready, m_req}, 32'd0);

        // R3/R5: byte reads over all bit positions of one byte
        for (int b = 0; b < 8; b++) access(ALIAS + 3*32 + b*4, 2'd0, 0, 32'd0, b % 3);
        // R2: halfword at odd byte address, word at misaligned byte, bit 31
        access(ALIAS + 5*32 + 9*4, 2'd1, 0, 32'd0, 1);
        access(ALIAS + 7*32 + 31*4, 2'd2, 0, 32'd0, 0);
        access(ALIAS + 10*32 + 20*4, 2'd3, 0, 32'd0, 2);
        // R2: top of window, upper alias bits ignored
        access(32'h23FF_FFFC, 2'd0, 0, 32'd0, 0);
        access(32'hFFFF_FFFC, 2'd2, 0, 32'd0, 1);
        // R6: set and clear bits in each size
        access(ALIAS + 12*32 + 2*4, 2'd0, 1, 32'd1, 0);
        access(ALIAS + 13*32 + 15*4, 2'd1, 1, 32'd1, 2);
        access(ALIAS + 17*32 + 31*4, 2'd2, 1, 32'd1, 3);
        access(ALIAS + 20*32 + 0*4, 2'd2, 1, 32'd0, 1);
        // R7: upper write-data bits disagree with bit 0
        access(ALIAS + 24*32 + 5*4, 2'd0, 1, 32'hFFFF_FFFE, 1);
        access(ALIAS + 25*32 + 5*4, 2'd0, 1, 32'h8000_0000, 0);
        access(ALIAS + 26*32 + 6*4, 2'd0, 1, 32'h0000_0003, 2);
        // read back a written bit
        access(ALIAS + 26*32 + 6*4, 2'd0, 0, 32'd0, 0);
        access(ALIAS + 24*32 + 5*4, 2'd0, 0, 32'd0, 1);

        begin
            int bad = 0;
            for (int i = 0; i < 64; i++) if (mem[i] !== shadow[i]) bad++;
            check(bad == 0, "R6/R7 target memory contents", bad, 32'd0);
        end
        check(exp_q.size() == 0, "R8 all responses seen", exp_q.size(), 32'd0);
        report();
    end
endmodule